// File: doc/BRIEF.md
# Hardware Monitor Control Register Block

This block holds the control state of a system hardware monitor. A simple synchronous register port reaches three registers: the configuration byte, a reset-enable byte and a test byte. The block decodes these registers into the control lines that the rest of the monitor uses. Those lines are run or low-power, interrupt enable, interrupt clear, chassis-intrusion clear, a timed reset pulse, an analog shutdown line and a one-cycle soft-initialization strobe.

The bits of these registers act on each other. Interrupt clear holds monitoring stopped. The shutdown bit in the test register stops monitoring and leaves all stored state as it is. The reset pulse starts only if the reset-enable register permits it. The init bit clears itself. It restores the configuration and reset-enable registers to their defaults, keeps the test register, and tells the other register files to initialize.

Top module: `mon_ctrl_regs`

## Requirements
- R1: After reset, the configuration register (address 0x40) reads 0x08, and the reset-enable register (0x44) and the test register (0x15) read 0x00. After reset, monitor_run_o=0, low_power_o=1, int_clr_o=1, int_en_o=0, ci_clr_o=0, analog_off_o=0, reset_pulse_o=0 and soft_init_o=0.
- R2: Configuration bit 0 drives low_power_o as its inverse. Configuration bit 1 drives int_en_o.
- R3: Configuration bit 3 drives int_clr_o, and monitoring stays stopped while this bit is set.
- R4: monitor_run_o = cfg[0] & ~cfg[3] & ~test[0]. analog_off_o = test[0].
- R5: Configuration bits 0, 1, 2, 3, 5 and 6 read back as written. Bits 4 and 7 always read 0. ci_clr_o follows bit 6. Writes are accepted in low-power mode.
- R6: A configuration write with bit 7 set discards the other bits of that write. It loads the configuration register with 0x08 and the reset-enable register with 0x00, and it leaves the test register unchanged. soft_init_o is high for exactly the one cycle after the write edge.
- R7: A configuration write with bit 4 set and bit 7 clear raises reset_pulse_o for exactly PULSE_CYCLES cycles, starting at the next edge, provided bit 7 of the reset-enable register is set. If that bit is clear, no pulse occurs.
- R8: A pulse request made while a pulse is running is ignored. The running pulse is neither extended nor restarted.
- R9: The test register stores all 8 bits. Setting test bit 0 stops monitoring and keeps the configuration contents. Clearing test bit 0 resumes the previous run state.
- R10: A write to any other address changes nothing, and a read of any other address returns 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low power-on reset |
| wr_en_i | input | 1 | Write strobe |
| addr_i | input | 8 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i (combinational) |
| monitor_run_o | output | 1 | Monitoring loop runs |
| low_power_o | output | 1 | Low-power mode |
| int_en_o | output | 1 | Interrupt output enable |
| int_clr_o | output | 1 | Interrupt output clear |
| ci_clr_o | output | 1 | Chassis-intrusion clear |
| reset_pulse_o | output | 1 | Timed reset pulse |
| analog_off_o | output | 1 | Full shutdown of the analog output |
| soft_init_o | output | 1 | One-cycle soft initialization strobe |

## Verification
The bench builds the block with PULSE_CYCLES=5 and keeps the address defaults. With this pulse length, the bench can measure the full pulse and a retrigger in the middle of a pulse cycle by cycle. With the width of 8 bits, it can sweep every configuration value that has bit 7 clear against both states of the shutdown bit. Every output and every readback is compared with values computed in the bench from the bit definitions.

// File: rtl/mon_ctrl_pkg.sv
package mon_ctrl_pkg;
  localparam int DW = 8;
  localparam int B_RUN    = 0;
  localparam int B_INT_EN = 1;
  localparam int B_INTCLR = 3;
  localparam int B_RSTREQ = 4;
  localparam int B_CICLR  = 6;
  localparam int B_INIT   = 7;
  localparam logic [DW-1:0] CFG_DEFAULT = 8'h08;
  localparam logic [DW-1:0] CFG_STORE   = 8'h6F;
  localparam int B_RST_EN = 7;
  localparam int B_SHDN   = 0;
endpackage

// File: rtl/mon_cfg_reg.sv
module mon_cfg_reg
  import mon_ctrl_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cfg_wr_i,
  input  logic          rsten_wr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] cfg_o,
  output logic [DW-1:0] rsten_o,
  output logic          init_o,
  output logic          pulse_req_o
);
  logic [DW-1:0] cfg_q, rsten_q;
  logic          init_q, init_req;

  assign init_req    = cfg_wr_i & wdata_i[B_INIT];
  assign pulse_req_o = cfg_wr_i & wdata_i[B_RSTREQ] & ~wdata_i[B_INIT] & rsten_q[B_RST_EN];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q   <= CFG_DEFAULT;
      rsten_q <= '0;
      init_q  <= 1'b0;
    end else begin
      init_q <= init_req;
      if (init_req) begin
        cfg_q   <= CFG_DEFAULT;
        rsten_q <= '0;
      end else begin
        if (cfg_wr_i)   cfg_q   <= wdata_i & CFG_STORE;
        if (rsten_wr_i) rsten_q <= wdata_i;
      end
    end
  end

  assign cfg_o   = cfg_q;
  assign rsten_o = rsten_q;
  assign init_o  = init_q;

  // R6
  init_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_o |=> !init_o);
  // R6
  init_defaults_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_o |-> (cfg_q == CFG_DEFAULT && rsten_q == '0));
  // R5
  cfg_unstored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_q[B_INIT] && !cfg_q[B_RSTREQ]);
endmodule

// File: rtl/mon_pulse_timer.sv
module mon_pulse_timer #(
  parameter int unsigned PULSE_CYCLES = 4_000_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic pulse_o
);
  localparam int CW = $clog2(PULSE_CYCLES + 1);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    cnt_q <= '0;
    else if (start_i && cnt_q == 0) cnt_q <= CW'(PULSE_CYCLES);
    else if (cnt_q != 0)            cnt_q <= cnt_q - 1'b1;
  end

  assign pulse_o = (cnt_q != 0);

  // R8
  countdown_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_o |=> cnt_q == CW'($past(cnt_q) - 1'b1));
  // R7
  no_spurious_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pulse_o && !start_i) |=> !pulse_o);
endmodule

// File: rtl/mon_test_reg.sv
module mon_test_reg
  import mon_ctrl_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] q_o
);
  logic [DW-1:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q <= '0;
    else if (wr_i) q <= wdata_i;
  end

  assign q_o = q;

  // R9
  test_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> $stable(q));
endmodule

// File: rtl/mon_ctrl_regs.sv
module mon_ctrl_regs
  import mon_ctrl_pkg::*;
#(
  parameter int unsigned   PULSE_CYCLES = 4_000_000,
  parameter logic [7:0]    CFG_ADDR     = 8'h40,
  parameter logic [7:0]    RSTEN_ADDR   = 8'h44,
  parameter logic [7:0]    TEST_ADDR    = 8'h15
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_en_i,
  input  logic [7:0] addr_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o,
  output logic       monitor_run_o,
  output logic       low_power_o,
  output logic       int_en_o,
  output logic       int_clr_o,
  output logic       ci_clr_o,
  output logic       reset_pulse_o,
  output logic       analog_off_o,
  output logic       soft_init_o
);
  logic [DW-1:0] cfg, rsten, test;
  logic          cfg_wr, rsten_wr, test_wr, pulse_req;

  assign cfg_wr   = wr_en_i && addr_i == CFG_ADDR;
  assign rsten_wr = wr_en_i && addr_i == RSTEN_ADDR;
  assign test_wr  = wr_en_i && addr_i == TEST_ADDR;

  mon_cfg_reg i_cfg (
    .clk_i, .rst_ni,
    .cfg_wr_i(cfg_wr), .rsten_wr_i(rsten_wr), .wdata_i,
    .cfg_o(cfg), .rsten_o(rsten), .init_o(soft_init_o), .pulse_req_o(pulse_req)
  );

  mon_test_reg i_test (
    .clk_i, .rst_ni, .wr_i(test_wr), .wdata_i, .q_o(test)
  );

  mon_pulse_timer #(.PULSE_CYCLES(PULSE_CYCLES)) i_timer (
    .clk_i, .rst_ni, .start_i(pulse_req), .pulse_o(reset_pulse_o)
  );

  always_comb begin
    unique case (addr_i)
      CFG_ADDR:   rdata_o = cfg;
      RSTEN_ADDR: rdata_o = rsten;
      TEST_ADDR:  rdata_o = test;
      default:    rdata_o = '0;
    endcase
  end

  assign monitor_run_o = cfg[B_RUN] & ~cfg[B_INTCLR] & ~test[B_SHDN];
  assign low_power_o   = ~cfg[B_RUN];
  assign int_en_o      = cfg[B_INT_EN];
  assign int_clr_o     = cfg[B_INTCLR];
  assign ci_clr_o      = cfg[B_CICLR];
  assign analog_off_o  = test[B_SHDN];

  // R4
  run_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    monitor_run_o |-> (!test[B_SHDN] && !int_clr_o && !low_power_o));
  // R9
  shutdown_keeps_cfg_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (test_wr && !cfg_wr) |=> $stable(cfg));
endmodule

// File: tb/test_mon_ctrl_regs.sv
module test_mon_ctrl_regs;
  localparam int PC = 5;
  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
  logic [7:0] addr = '0, wdata = '0, rdata;
  logic run, lp, ien, iclr, ci, pulse, aoff, init;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  mon_ctrl_regs #(.PULSE_CYCLES(PC)) i_mon_ctrl_regs (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .monitor_run_o(run), .low_power_o(lp), .int_en_o(ien),
    .int_clr_o(iclr), .ci_clr_o(ci), .reset_pulse_o(pulse), .analog_off_o(aoff),
    .soft_init_o(init)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [7:0] d);
    addr = a; #0.5; d = rdata;
  endtask

  function automatic logic [7:0] outs_exp(logic [7:0] c, logic t0);
    // {run, lp, ien, iclr, ci, aoff, pulse, init}
    return {c[0] & ~c[3] & ~t0, ~c[0], c[1], c[3], c[6], t0, 1'b0, 1'b0};
  endfunction

  function automatic logic [7:0] outs_act();
    return {run, lp, ien, iclr, ci, aoff, pulse, init};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd(8'h40, d); check("R1 cfg", d, 8'h08);
    rd(8'h44, d); check("R1 rsten", d, 8'h00);
    rd(8'h15, d); check("R1 test", d, 8'h00);
    check("R1 outputs", outs_act(), outs_exp(8'h08, 1'b0));

    // R2 R3 R4 R5 sweep; rsten=0 so bit 4 never pulses (R7)
    for (int v = 0; v < 128; v++) begin
      for (int t = 0; t < 2; t++) begin
        wr(8'h15, 8'(t));
        wr(8'h40, 8'(v));
        rd(8'h40, d); check("R5 cfg readback", d, 8'(v) & 8'h6F);
        rd(8'h15, d); check("R9 test readback", d, 8'(t));
        check("R2/R3/R4 outputs", outs_act(), outs_exp(8'(v), t[0]));
      end
    end

    // R9 full test width and resume
    wr(8'h15, 8'hA5); rd(8'h15, d); check("R9 test 8 bits", d, 8'hA5);
    wr(8'h40, 8'h03);
    check("R9 shutdown stops run", {run, aoff}, 2'b01);
    rd(8'h40, d); check("R9 cfg kept", d, 8'h03);
    wr(8'h15, 8'h00);
    check("R9 resume", {run, aoff}, 2'b10);

    // R10 unmapped address
    wr(8'h20, 8'hFF);
    rd(8'h20, d); check("R10 unmapped read", d, 8'h00);
    rd(8'h40, d); check("R10 cfg unchanged", d, 8'h03);
    rd(8'h44, d); check("R10 rsten unchanged", d, 8'h00);

    // R7 pulse length
    wr(8'h44, 8'h80);
    wr(8'h40, 8'h11);
    n = 0;
    while (pulse && n < 50) begin n++; @(negedge clk); end
    check("R7 pulse length", n, PC);
    rd(8'h40, d); check("R7 bit4 reads 0", d, 8'h01);

    // R8 retrigger during pulse
    wr(8'h40, 8'h10);
    n = 0;
    for (int i = 0; i < 12; i++) begin
      if (pulse) n++;
      wr_en = (i == 2); addr = 8'h40; wdata = 8'h10;
      @(negedge clk);
    end
    wr_en = 1'b0;
    check("R8 pulse not extended", n, PC);

    // R7 no pulse when enable clear
    wr(8'h44, 8'h00);
    wr(8'h40, 8'h10);
    n = 0;
    for (int i = 0; i < 8; i++) begin if (pulse) n++; @(negedge clk); end
    check("R7 no pulse when disabled", n, 0);

    // R6 soft init
    wr(8'h44, 8'h80);
    wr(8'h15, 8'h5A);
    wr(8'h40, 8'h63);
    wr(8'h40, 8'hFF);
    check("R6 init strobe", init, 1'b1);
    check("R6 no pulse on init", pulse, 1'b0);
    rd(8'h40, d); check("R6 cfg default", d, 8'h08);
    rd(8'h44, d); check("R6 rsten cleared", d, 8'h00);
    rd(8'h15, d); check("R6 test kept", d, 8'h5A);
    @(negedge clk);
    check("R6 strobe one cycle", init, 1'b0);
    check("R6 outputs after init", outs_act(), outs_exp(8'h08, 1'b0));

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule